// File: doc/BRIEF.md
# Quadrature Up/Down Event Counter

This block is a 16-bit event counter that software controls through four word registers. It has four counting sources. A free-running timer counts down at a fixed fraction of the system clock. An up/down mode counts up on selected edges of input A and down on selected edges of input B. Two quadrature modes decode the A/B pair as a phase-shifted encoder signal, at double or at quadruple resolution. All three pins pass through two-flop synchronisers before any edge is detected.

The counter can wrap, or it can reload from the reload/compare register on underflow. It can clear itself when a count event arrives while it equals that register. Software can load the counter from that register or clear it. Pin Z either clears the counter on a rising edge or gates counting while it is low. Sticky overflow and underflow flags and a direction bit report what happened.

Register map (word address, `wdata`/`rdata` bit positions):

- Address 0, control: bit0 run, bits2:1 mode, bits4:3 edge select, bit5 compare-clear enable, bit6 reload enable, bit7 Z gate mode, bit8 spare, bit9 load action, bit10 clear action (active low).
- Address 1: reload/compare value.
- Address 2: counter value, read-only.
- Address 3, status: bit0 overflow, bit1 underflow, bit2 direction.

Top module: `qdc_counter`

## Requirements
- R1: After reset, the counter reads 0, the status register reads 0, and the control register reads 0x0400: bit10 always reads 1, bit9 always reads 0, and all other bits read 0.
- R2: With mode 00 (timer) and run=1, the counter decrements once every TICK_DIV clocks (default 4), with the first decrement on the fourth edge after the control write. Pins A and B have no effect in this mode.
- R3: In mode 01 (up/down), the edge select chooses which edges count: 00 none, 01 falling, 10 rising, 11 both. A selected edge on A adds 1 and a selected edge on B subtracts 1. Selected edges on A and B in the same cycle leave the count unchanged.
- R4: In mode 10 (quadrature ×2), each edge of B counts up when A is high and down when A is low. Edges of A alone do not count.
- R5: In mode 11 (quadrature ×4), every single-pin change of the {A,B} Gray sequence counts. The sequence 00→10→11→01→00 counts up and the reverse counts down. A change of both pins at once does not count.
- R6: A step up from 0xFFFF gives 0x0000 and sets the overflow flag. A step down from 0x0000 sets the underflow flag. Both flags are sticky. Writing status with bit0=0 clears overflow, and writing it with bit1=0 clears underflow. Status bit2 is 1 after an up count and 0 after a down count.
- R7: A step down from 0x0000 loads the reload value when reload enable (bit6) is 1, and gives 0xFFFF when it is 0.
- R8: With compare-clear enable (bit5) set, a count event that arrives while the counter equals the reload value clears the counter to 0.
- R9: A control write with bit9=1 copies the reload value into the counter.
- R10: A control write with bit10=0 clears the counter. A control write with bit10=1 leaves the counter unchanged.
- R11: With Z gate mode 0, a rising edge on Z clears the counter. With Z gate mode 1, counting is blocked while Z is low, and Z does not clear the counter.
- R12: With run=0 the counter holds its value. Writes to address 2 do not change the counter. The spare bit8 reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for `addr` |
| pin_a | input | 1 | Count input A (asynchronous) |
| pin_b | input | 1 | Count input B (asynchronous) |
| pin_z | input | 1 | Clear or gate input Z (asynchronous) |
| count_o | output | 16 | Current counter value |

## Verification
The hardest situations to reach are the ones where several update sources compete in one cycle. Examples are a count event that arrives at the compare value, a down count that reaches zero with reload enabled, and opposite-direction edges on A and B in the same synchronised cycle. The bench loads exact start values through the reload register and the load action. It then toggles both pins in the same cycle so that their edges pass through the synchronisers together. It walks the Gray sequence forward, backward and with an illegal double step, and it reads the sticky flags after each wrap before it clears them one at a time.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_UPDN  = 2'b01,
    MODE_QX2   = 2'b10,
    MODE_QX4   = 2'b11
  } cnt_mode_e;

  // Control register layout; the first member is the most significant bit.
  typedef struct packed {
    logic       spare;
    logic       z_gate;
    logic       rld_en;
    logic       cmp_en;
    logic [1:0] edge_sel;
    cnt_mode_e  mode;
    logic       run;
  } ctrl_t;

  localparam int LOAD_BIT = 9;
  localparam int CLRN_BIT = 10;

endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/qdc_tick_gen.sv
module qdc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc;

      always_ff @(posedge clk) begin
        if (rst || !en)      pc <= '0;
        else if (pc == LAST) pc <= '0;
        else                 pc <= pc + 1'b1;
      end

      assign tick = en && (pc == LAST);

      // R2: timer ticks never come on back-to-back cycles
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/qdc_event_dec.sv
module qdc_event_dec
  import qdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a_s,
  input  logic       b_s,
  input  logic       z_s,
  input  cnt_mode_e  mode,
  input  logic [1:0] edge_sel,
  output logic       up,
  output logic       dn,
  output logic       z_rise
);

  logic a_d, b_d, z_d;
  logic ev_a, ev_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d <= 1'b0;
      b_d <= 1'b0;
      z_d <= 1'b0;
    end else begin
      a_d <= a_s;
      b_d <= b_s;
      z_d <= z_s;
    end
  end

  function automatic logic pick(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      2'b01:   return fall;
      2'b10:   return rise;
      2'b11:   return rise | fall;
      default: return 1'b0;
    endcase
  endfunction

  assign z_rise = z_s & ~z_d;

  always_comb begin
    up   = 1'b0;
    dn   = 1'b0;
    ev_a = pick(edge_sel, a_s & ~a_d, ~a_s & a_d);
    ev_b = pick(edge_sel, b_s & ~b_d, ~b_s & b_d);
    case (mode)
      MODE_UPDN: begin
        up = ev_a & ~ev_b;
        dn = ev_b & ~ev_a;
      end
      MODE_QX2: begin
        if (b_s != b_d) begin
          up = a_s;
          dn = ~a_s;
        end
      end
      MODE_QX4: begin
        // exactly one pin changed: direction follows Gray order
        if ((a_s ^ a_d) ^ (b_s ^ b_d)) begin
          up = a_s ^ b_d;
          dn = ~(a_s ^ b_d);
        end
      end
      default: ;
    endcase
  end

  // R3: one direction per cycle at most
  p_dir_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(up && dn));

  // R4: without a B edge the x2 decoder stays silent
  p_x2_needs_b_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QX2 && b_s == b_d) |-> (!up && !dn));

endmodule

// File: rtl/qdc_count_core.sv
module qdc_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up,
  input  logic         dn,
  input  logic         sw_clr,
  input  logic         sw_load,
  input  logic         z_clr,
  input  logic         cmp_en,
  input  logic         rld_en,
  input  logic         clr_ovf,
  input  logic         clr_unf,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_q,
  output logic         ovf_q,
  output logic         unf_q,
  output logic         dir_q
);

  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_d;
  logic         ovf_set, unf_set, step, ext;

  assign step = up | dn;
  assign ext  = sw_clr | sw_load | z_clr;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    if (sw_clr) begin
      cnt_d = '0;
    end else if (sw_load) begin
      cnt_d = reload;
    end else if (z_clr) begin
      cnt_d = '0;
    end else if (step) begin
      if (cmp_en && cnt_q == reload) begin
        cnt_d = '0;
      end else if (up) begin
        cnt_d   = cnt_q + 1'b1;
        ovf_set = (cnt_q == CMAX);
      end else if (cnt_q == '0) begin
        unf_set = 1'b1;
        cnt_d   = rld_en ? reload : CMAX;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_set | (ovf_q & ~clr_ovf);
      unf_q <= unf_set | (unf_q & ~clr_unf);
      if (step && !ext) dir_q <= up;
    end
  end

  // R10: software clear wins over everything
  p_sw_clear_r10: assert property (@(posedge clk) disable iff (rst)
    sw_clr |=> (cnt_q == '0));

  // R9: software load copies the reload value
  p_sw_load_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_load && !sw_clr) |=> (cnt_q == $past(reload)));

  // R12: no source active means the value holds
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!ext && !step) |=> (cnt_q == $past(cnt_q)));

  // R7: underflow with reload enabled loads the reload value
  p_unf_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (!ext && dn && !up && cnt_q == '0 && rld_en && !(cmp_en && reload == '0))
      |=> (cnt_q == $past(reload) && unf_q));

  // R8: count event at the compare value clears
  p_cmp_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!ext && step && cmp_en && cnt_q == reload) |=> (cnt_q == '0));

  // R6: overflow flag stays until cleared
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);

endmodule

// File: rtl/qdc_counter.sv
module qdc_counter
  import qdc_pkg::*;
#(
  parameter int W        = 16,
  parameter int TICK_DIV = 4,
  parameter int SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         pin_z,
  output logic [W-1:0] count_o
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t        ctrl_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] ctrl_rd, stat_rd;
  logic [2:0]   pins_s;
  logic         dec_up, dec_dn, z_rise, tick;
  logic         ok, up, dn, z_clr;
  logic         wr_ctrl, wr_stat, sw_clr, sw_load;
  logic         ovf, unf, dir;

  assign wr_ctrl = wr_en && (addr == 2'd0);
  assign wr_stat = wr_en && (addr == 2'd3);
  assign sw_clr  = wr_ctrl && !wdata[CLRN_BIT];
  assign sw_load = wr_ctrl && wdata[LOAD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0:    ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        2'd1:    reload_q <= wdata;
        default: ;
      endcase
    end
  end

  qdc_sync #(.N(3), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pin_z, pin_b, pin_a}),
    .q   (pins_s)
  );

  qdc_event_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .a_s      (pins_s[0]),
    .b_s      (pins_s[1]),
    .z_s      (pins_s[2]),
    .mode     (ctrl_q.mode),
    .edge_sel (ctrl_q.edge_sel),
    .up       (dec_up),
    .dn       (dec_dn),
    .z_rise   (z_rise)
  );

  qdc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (ctrl_q.run && ctrl_q.mode == MODE_TIMER),
    .tick (tick)
  );

  assign ok    = ctrl_q.run && (!ctrl_q.z_gate || pins_s[2]);
  assign up    = ok && dec_up;
  assign dn    = ok && (dec_dn || tick);
  assign z_clr = !ctrl_q.z_gate && z_rise;

  qdc_count_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .up      (up),
    .dn      (dn),
    .sw_clr  (sw_clr),
    .sw_load (sw_load),
    .z_clr   (z_clr),
    .cmp_en  (ctrl_q.cmp_en),
    .rld_en  (ctrl_q.rld_en),
    .clr_ovf (wr_stat && !wdata[0]),
    .clr_unf (wr_stat && !wdata[1]),
    .reload  (reload_q),
    .cnt_q   (count_o),
    .ovf_q   (ovf),
    .unf_q   (unf),
    .dir_q   (dir)
  );

  always_comb begin
    ctrl_rd               = '0;
    ctrl_rd[CTRL_W-1:0]   = ctrl_q;
    ctrl_rd[CLRN_BIT]     = 1'b1;
    stat_rd               = '0;
    stat_rd[2:0]          = {dir, unf, ovf};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        2'd0:    rdata <= ctrl_rd;
        2'd1:    rdata <= reload_q;
        2'd2:    rdata <= count_o;
        default: rdata <= stat_rd;
      endcase
    end
  end

  // R11: in gate mode Z low blocks every count
  p_gate_block_r11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.z_gate && !pins_s[2]) |-> (!up && !dn));

endmodule

// File: tb/tb_qdc_counter.sv
`timescale 1ns/1ps
module tb_qdc_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count_o;
  logic        pin_a = 1'b0, pin_b = 1'b0, pin_z = 1'b0;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  qdc_counter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .pin_z(pin_z), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pins(input logic a, input logic b);
    pin_a = a; pin_b = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic zpin(input logic z);
    pin_z = z;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_count(input logic [15:0] v);
    wr(2'd1, v);
    wr(2'd0, 16'h0600);
  endtask

  task automatic expect_cnt(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(2'd2, v);
    chk(req, v, exp);
  endtask

  task automatic expect_stat(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(2'd3, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0400);
    expect_cnt("R1 count", 16'h0000);
    expect_stat("R1 status", 16'h0000);
  endtask

  task automatic t_timer;
    set_count(16'd10);
    wr(2'd0, 16'h0401);
    pin_a = 1'b1;
    repeat (17) @(negedge clk);
    wr(2'd0, 16'h0400);
    pin_a = 1'b0;
    expect_cnt("R2 timer four ticks", 16'd6);
    repeat (20) @(negedge clk);
    expect_cnt("R12 run=0 holds", 16'd6);
  endtask

  task automatic t_sw;
    set_count(16'd77);
    expect_cnt("R9 load from reload", 16'd77);
    wr(2'd0, 16'h0400);
    expect_cnt("R10 clear bit high no effect", 16'd77);
    wr(2'd0, 16'h0000);
    expect_cnt("R10 clear bit low clears", 16'd0);
  endtask

  task automatic t_updown;
    set_count(16'd100);
    wr(2'd0, 16'h0413);
    for (int i = 0; i < 3; i++) begin pins(1, 0); pins(0, 0); end
    expect_cnt("R3 rising A x3", 16'd103);
    pins(0, 1); pins(0, 0);
    expect_cnt("R3 rising B", 16'd102);
    pins(1, 1); pins(0, 0);
    expect_cnt("R3 simultaneous cancel", 16'd102);
    wr(2'd0, 16'h040B);
    pins(1, 0); pins(0, 0);
    expect_cnt("R3 falling edge", 16'd103);
    wr(2'd0, 16'h0403);
    pins(1, 0); pins(0, 0);
    expect_cnt("R3 edges disabled", 16'd103);
    wr(2'd0, 16'h041B);
    pins(1, 0); pins(0, 0);
    expect_cnt("R3 both edges", 16'd105);
    expect_stat("R6 dir up", 16'h0004);
    pins(0, 1); pins(0, 0);
    expect_cnt("R3 both edges B", 16'd103);
    expect_stat("R6 dir down", 16'h0000);
  endtask

  task automatic t_x2;
    set_count(16'd50);
    pins(1, 0);
    wr(2'd0, 16'h0405);
    pins(1, 1); pins(1, 0);
    expect_cnt("R4 B edges with A high", 16'd52);
    pins(0, 0);
    expect_cnt("R4 A edge ignored", 16'd52);
    pins(0, 1); pins(0, 0);
    expect_cnt("R4 B edges with A low", 16'd50);
  endtask

  task automatic t_x4;
    set_count(16'd20);
    wr(2'd0, 16'h0407);
    pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
    expect_cnt("R5 forward cycle", 16'd24);
    pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
    expect_cnt("R5 reverse cycle", 16'd20);
    pins(1, 1);
    expect_cnt("R5 double step ignored", 16'd20);
    pins(0, 0);
  endtask

  task automatic t_wrap;
    wr(2'd3, 16'h0000);
    set_count(16'd0);
    wr(2'd0, 16'h0413);
    pins(0, 1); pins(0, 0);
    expect_cnt("R7 wrap without reload", 16'hFFFF);
    expect_stat("R6 underflow flag", 16'h0002);
    pins(1, 0); pins(0, 0);
    expect_cnt("R6 overflow wrap", 16'h0000);
    expect_stat("R6 both flags sticky", 16'h0007);
    wr(2'd3, 16'h0002);
    expect_stat("R6 clear overflow only", 16'h0006);
    wr(2'd3, 16'h0000);
    expect_stat("R6 clear all flags", 16'h0004);
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0453);
    pins(0, 1); pins(0, 0);
    expect_cnt("R7 reload on underflow", 16'd5);
  endtask

  task automatic t_compare;
    set_count(16'd0);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0433);
    for (int i = 0; i < 3; i++) begin pins(1, 0); pins(0, 0); end
    expect_cnt("R8 reaches compare value", 16'd3);
    pins(1, 0); pins(0, 0);
    expect_cnt("R8 compare clear", 16'd0);
  endtask

  task automatic t_zpin;
    set_count(16'd40);
    wr(2'd0, 16'h0413);
    zpin(1); zpin(0);
    expect_cnt("R11 Z rising clears", 16'd0);
    set_count(16'd40);
    wr(2'd0, 16'h0493);
    pins(1, 0); pins(0, 0);
    expect_cnt("R11 gate low blocks", 16'd40);
    zpin(1);
    expect_cnt("R11 Z in gate mode no clear", 16'd40);
    pins(1, 0); pins(0, 0);
    expect_cnt("R11 gate high counts", 16'd41);
    zpin(0);
  endtask

  task automatic t_misc;
    logic [15:0] v;
    wr(2'd2, 16'h1234);
    expect_cnt("R12 count write ignored", 16'd41);
    wr(2'd0, 16'h0500);
    rd(2'd0, v); chk("R12 spare readback", v, 16'h0500);
    wr(2'd0, 16'h0700);
    rd(2'd0, v); chk("R1 load bit reads 0", v, 16'h0500);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timer();
    t_sw();
    t_updown();
    t_x2();
    t_x4();
    t_wrap();
    t_compare();
    t_zpin();
    t_misc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule